// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Select

This block accumulates events seen on one input pin into a 16-bit count. It runs in one of two modes. In edge mode each selected transition of the pin adds one to the count. In gated mode the pin acts as a gate: while the pin sits at its active level, every divide-by-64 tick from the timer prescaler adds one. In both modes the selected transition sets an input flag. Each time the count wraps from all ones to zero, an overflow flag is set. Both flags are cleared by writing 1 to them, and each flag drives an interrupt request through its own enable.

The block also picks the clock enable for the main timer counter. It can pass on the prescaler tick, the accumulator's own increment, the carry out of the low byte (the increment divided by 256), or the carry out of the full counter (divided by 65536). While the accumulator is disabled, the prescaler tick is always passed on. Software can also load the count directly through a write strobe.

Top module: `pulse_accum_top`

## Requirements
- R1: With acc_en=1 and mode_gated=0, the count goes up by one for each falling pin edge when edge_pol=0, and for each rising pin edge when edge_pol=1. Other pin activity leaves it unchanged. The pin passes through two synchroniser flops, so the count changes on the third rising clock edge after the pin changes.
- R2: With acc_en=1 and mode_gated=1, the count goes up by one for each cycle in which div64_tick=1 and the synchronised pin is at its active level. The active level is high when edge_pol=0 and low when edge_pol=1.
- R3: In gated mode, while timer_en=0 the divide-by-64 tick is ignored and the count holds. Counting resumes once timer_en returns to 1.
- R4: With acc_en=1, inp_flag is set by a falling edge when edge_pol=0 and by a rising edge when edge_pol=1. This holds in both modes; in gated mode that edge is the one that ends the active level.
- R5: When an increment takes the count from 16'hFFFF to 16'h0000, ovf_flag is set.
- R6: A cycle with inp_clr=1 or ovf_clr=1 clears the matching flag. If the flag is set and cleared in the same cycle, the flag ends up set.
- R7: inp_irq is 1 exactly when inp_ie=1 and inp_flag=1. ovf_irq is 1 exactly when ovf_ie=1 and ovf_flag=1.
- R8: With acc_en=0, pin activity changes neither the count nor the flags, mode_gated and edge_pol have no effect, and tcnt_tick equals presc_tick whatever clk_sel holds.
- R9: With acc_en=1, clk_sel chooses tcnt_tick combinationally, so a new value applies in the same cycle it is written. The codes are: 2'b00 gives presc_tick; 2'b01 gives the accumulator increment; 2'b10 gives an increment that carries out of the low byte (count[7:0]=8'hFF); 2'b11 gives an increment that carries out of the full count (count=16'hFFFF).
- R10: cnt_we=1 loads cnt_wdata into the count on the next clock edge. A load overrides an increment in the same cycle, and that increment then produces no carry and no overflow.
- R11: After reset, cnt_q=0 and both flags and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous event pin |
| timer_en | input | 1 | Timer enable; gates the divide-by-64 tick |
| presc_tick | input | 1 | Timer prescaler tick |
| div64_tick | input | 1 | Bus clock divided by 64 tick from the prescaler |
| acc_en | input | 1 | Accumulator enable |
| mode_gated | input | 1 | 0 edge mode, 1 gated mode |
| edge_pol | input | 1 | Edge and level polarity select |
| clk_sel | input | 2 | Timer counter clock select |
| ovf_ie | input | 1 | Overflow interrupt enable |
| inp_ie | input | 1 | Input interrupt enable |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| inp_clr | input | 1 | Write-1 clear of the input flag |
| cnt_we | input | 1 | Count load strobe |
| cnt_wdata | input | 16 | Count load value |
| cnt_q | output | 16 | Accumulated count |
| inp_flag | output | 1 | Input edge flag |
| ovf_flag | output | 1 | Overflow flag |
| inp_irq | output | 1 | Input interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| tcnt_tick | output | 1 | Clock enable for the main timer counter |

## Verification
The assertions assume that cnt_we is the only way the count can change by anything other than a single step. They also assume that no control input changes while reset is asserted, so that $past values taken from the reset cycle are meaningful. The bench drives every input at the falling clock edge. It holds each pin level for four cycles, which is longer than the two-flop synchroniser delay, and it pulses the divide-by-64 tick only in the cycle after the synchronised pin has settled. Loads and flag clears are issued only after the pin has been quiet for several cycles, except in the one test that deliberately makes a clear coincide with a set.

// File: rtl/pa_pkg.sv
// Package: shared types for the pulse accumulator.
// Assumes: clk_sel is a two-bit code whose encoding the clock mux decodes.
package pa_pkg;
    typedef enum logic [1:0] {
        TSEL_PRESC = 2'b00,
        TSEL_ACC   = 2'b01,
        TSEL_LOW   = 2'b10,
        TSEL_FULL  = 2'b11
    } tsel_e;
endpackage

// File: rtl/pa_sync_edge.sv
// Module: pa_sync_edge
// Synchronises an asynchronous pin through a flop chain and reports the
// settled level and single-cycle rise and fall pulses.
// Assumes: STAGES >= 2; the pin may change at any time.
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First synchroniser stage samples the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= din;
            end
        end else begin : g_next
            // Later stages shift the sampled value along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Remember the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[STAGES-1];
    end

    // Derive level and edge pulses from the settled value.
    always_comb begin
        level = chain[STAGES-1];
        rise  = chain[STAGES-1] & ~prev_q;
        fall  = ~chain[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/pa_counter.sv
// Module: pa_counter
// Loadable up-counter with carry pulses out of the low field and out of the
// whole counter.
// Assumes: a load has priority; an increment lost to a load emits no carry.
module pa_counter #(
    parameter int W     = 16,
    parameter int LOW_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] ldata,
    output logic [W-1:0] count,
    output logic         step,
    output logic         carry_low,
    output logic         carry_full
);
    logic [W-1:0] cnt_q;

    // Qualify the increment and compute the carry outs.
    always_comb begin
        step       = inc & ~load;
        carry_low  = step & (&cnt_q[LOW_W-1:0]);
        carry_full = step & (&cnt_q);
        count      = cnt_q;
    end

    // Count register: load first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= ldata;
        else if (inc)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pa_clk_mux.sv
// Module: pa_clk_mux
// Selects the clock enable for the main timer counter.
// Assumes: all tick inputs are single-cycle enables in the bus clock domain.
module pa_clk_mux
    import pa_pkg::*;
(
    input  logic       acc_en,
    input  logic [1:0] sel,
    input  logic       presc_tick,
    input  logic       acc_tick,
    input  logic       low_tick,
    input  logic       full_tick,
    output logic       tcnt_tick
);
    // Combinational select; a disabled accumulator forces the prescaler.
    always_comb begin
        if (!acc_en) begin
            tcnt_tick = presc_tick;
        end else begin
            case (tsel_e'(sel))
                TSEL_PRESC: tcnt_tick = presc_tick;
                TSEL_ACC:   tcnt_tick = acc_tick;
                TSEL_LOW:   tcnt_tick = low_tick;
                TSEL_FULL:  tcnt_tick = full_tick;
                default:    tcnt_tick = presc_tick;
            endcase
        end
    end
endmodule

// File: rtl/pulse_accum_top.sv
// Module: pulse_accum_top
// Pulse accumulator: edge counting or gated divide-by-64 time counting on
// one pin, with input and overflow flags, interrupt requests, and the timer
// counter clock select.
// Assumes: control inputs are register-interface levels; clears are strobes.
module pulse_accum_top #(
    parameter int CNT_W  = 16,
    parameter int LOW_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             timer_en,
    input  logic             presc_tick,
    input  logic             div64_tick,
    input  logic             acc_en,
    input  logic             mode_gated,
    input  logic             edge_pol,
    input  logic [1:0]       clk_sel,
    input  logic             ovf_ie,
    input  logic             inp_ie,
    input  logic             ovf_clr,
    input  logic             inp_clr,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             inp_flag,
    output logic             ovf_flag,
    output logic             inp_irq,
    output logic             ovf_irq,
    output logic             tcnt_tick
);
    logic pin_lvl, pin_rise, pin_fall;
    logic sel_edge, active_lvl, gate_tick, acc_inc;
    logic step, carry_low, carry_full;
    logic inp_q, ovf_q;

    pa_sync_edge #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    // Pick the selected edge, the active gate level and the increment source.
    always_comb begin
        sel_edge   = edge_pol ? pin_rise : pin_fall;
        active_lvl = edge_pol ? ~pin_lvl : pin_lvl;
        gate_tick  = div64_tick & timer_en & active_lvl;
        acc_inc    = acc_en & (mode_gated ? gate_tick : sel_edge);
    end

    pa_counter #(.W(CNT_W), .LOW_W(LOW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (acc_inc),
        .load       (cnt_we),
        .ldata      (cnt_wdata),
        .count      (cnt_q),
        .step       (step),
        .carry_low  (carry_low),
        .carry_full (carry_full)
    );

    pa_clk_mux u_mux (
        .acc_en     (acc_en),
        .sel        (clk_sel),
        .presc_tick (presc_tick),
        .acc_tick   (step),
        .low_tick   (carry_low),
        .full_tick  (carry_full),
        .tcnt_tick  (tcnt_tick)
    );

    // Input flag: set by the selected edge, write-1 clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                  inp_q <= 1'b0;
        else if (acc_en && sel_edge) inp_q <= 1'b1;
        else if (inp_clr)            inp_q <= 1'b0;
    end

    // Overflow flag: set on full-counter wrap, write-1 clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf_q <= 1'b0;
        else if (carry_full) ovf_q <= 1'b1;
        else if (ovf_clr)    ovf_q <= 1'b0;
    end

    // Flags and masked interrupt requests.
    always_comb begin
        inp_flag = inp_q;
        ovf_flag = ovf_q;
        inp_irq  = inp_q & inp_ie;
        ovf_irq  = ovf_q & ovf_ie;
    end
endmodule

// File: rtl/pa_checker.sv
// Module: pa_checker
// Temporal checks on the pulse accumulator ports; bound to the top.
// Assumes: clocked by the bus clock, reset held for at least one edge.
module pa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        timer_en,
    input logic        presc_tick,
    input logic        acc_en,
    input logic        mode_gated,
    input logic        cnt_we,
    input logic [15:0] cnt_q,
    input logic        ovf_flag,
    input logic        inp_flag,
    input logic        inp_irq,
    input logic        ovf_irq,
    input logic        tcnt_tick
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 16'd1)); // R1
    AST_GATE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode_gated && !timer_en && !cnt_we) |=> $stable(cnt_q)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt_q == 16'h0000)); // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (inp_irq |-> inp_flag) and (ovf_irq |-> ovf_flag)); // R7
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !cnt_we) |=> $stable(cnt_q)); // R8
    AST_DISABLED_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (tcnt_tick == presc_tick)); // R8
endmodule

bind pulse_accum_top pa_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_en   (timer_en),
    .presc_tick (presc_tick),
    .acc_en     (acc_en),
    .mode_gated (mode_gated),
    .cnt_we     (cnt_we),
    .cnt_q      (cnt_q),
    .ovf_flag   (ovf_flag),
    .inp_flag   (inp_flag),
    .inp_irq    (inp_irq),
    .ovf_irq    (ovf_irq),
    .tcnt_tick  (tcnt_tick)
);

// File: tb/sim_pulse_accum_top.sv
`timescale 1ns/100ps
// Bench: vector table for both modes, then directed corner-case tests.
module sim_pulse_accum_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0, timer_en = 1'b1, presc_tick = 1'b0, div64_tick = 1'b0;
    logic        acc_en = 1'b0, mode_gated = 1'b0, edge_pol = 1'b0;
    logic [1:0]  clk_sel = 2'b00;
    logic        ovf_ie = 1'b0, inp_ie = 1'b0, ovf_clr = 1'b0, inp_clr = 1'b0, cnt_we = 1'b0;
    logic [15:0] cnt_wdata = 16'h0;
    logic [15:0] cnt_q;
    logic        inp_flag, ovf_flag, inp_irq, ovf_irq, tcnt_tick;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    pulse_accum_top u0 (.*);

    typedef struct packed {
        logic        mode;
        logic        pol;
        logic [7:0]  seq;
        logic [15:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h56, 16'd3, 1'b1},
        '{1'b0, 1'b1, 8'h56, 16'd3, 1'b1},
        '{1'b0, 1'b1, 8'h0E, 16'd1, 1'b1},
        '{1'b0, 1'b0, 8'hFF, 16'd0, 1'b0},
        '{1'b1, 1'b0, 8'h56, 16'd4, 1'b1},
        '{1'b1, 1'b1, 8'h56, 16'd3, 1'b1},
        '{1'b1, 1'b0, 8'hFF, 16'd7, 1'b0},
        '{1'b1, 1'b1, 8'h0E, 16'd4, 1'b1},
        '{1'b0, 1'b0, 8'h0E, 16'd1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold one pin level for four cycles; pulse the tick once after it settles.
    task automatic hold_bit(input logic b, input logic tk);
        pin_in = b;
        @(posedge clk); @(posedge clk); @(negedge clk);
        div64_tick = tk;
        @(posedge clk); @(negedge clk);
        div64_tick = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic load_and_clear(input logic [15:0] v);
        cnt_we = 1'b1; cnt_wdata = v; inp_clr = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0; inp_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    // Raise the pin and stop in the cycle where the synchronised edge is seen.
    task automatic open_rise();
        pin_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 count", cnt_q, 16'h0);
        check("R11 flags", {inp_flag, ovf_flag, inp_irq, ovf_irq}, 4'b0);

        acc_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            mode_gated = VECS[i].mode;
            edge_pol   = VECS[i].pol;
            pin_in     = VECS[i].seq[0];
            repeat (4) @(negedge clk);
            load_and_clear(16'h0);
            for (int k = 1; k < 8; k++) hold_bit(VECS[i].seq[k], VECS[i].mode);
            repeat (2) @(negedge clk);
            check(VECS[i].mode ? "R2 gated count" : "R1 edge count", cnt_q, VECS[i].exp_cnt);
            check("R4 input flag", inp_flag, VECS[i].exp_flag);
        end

        // R3: gated counting stalls while the timer is off.
        mode_gated = 1'b1; edge_pol = 1'b0; pin_in = 1'b1;
        repeat (4) @(negedge clk);
        load_and_clear(16'h0);
        timer_en = 1'b0;
        for (int k = 0; k < 3; k++) hold_bit(1'b1, 1'b1);
        check("R3 stalled", cnt_q, 16'h0);
        timer_en = 1'b1;
        hold_bit(1'b1, 1'b1);
        check("R3 resumes", cnt_q, 16'h1);

        // R8: disabled accumulator ignores the pin; prescaler drives the timer.
        acc_en = 1'b0; mode_gated = 1'b0; clk_sel = 2'b01;
        load_and_clear(16'h0);
        hold_bit(1'b0, 1'b1); hold_bit(1'b1, 1'b1); hold_bit(1'b0, 1'b1);
        check("R8 count held", cnt_q, 16'h0);
        check("R8 flag held", inp_flag, 1'b0);
        presc_tick = 1'b1; #0.5;
        check("R8 presc pass 1", tcnt_tick, 1'b1);
        presc_tick = 1'b0; #0.5;
        check("R8 presc pass 0", tcnt_tick, 1'b0);
        @(negedge clk);

        // R10 and R5: load all ones, one rising edge wraps to zero.
        acc_en = 1'b1; edge_pol = 1'b1; clk_sel = 2'b00;
        repeat (4) @(negedge clk);
        load_and_clear(16'hFFFF);
        check("R10 load", cnt_q, 16'hFFFF);
        hold_bit(1'b1, 1'b0);
        check("R5 wrap count", cnt_q, 16'h0);
        check("R5 overflow flag", ovf_flag, 1'b1);
        check("R7 irq masked", {inp_irq, ovf_irq}, 2'b00);
        ovf_ie = 1'b1; inp_ie = 1'b1; #0.5;
        check("R7 irq enabled", {inp_irq, ovf_irq}, 2'b11);
        @(negedge clk);

        // R6: write-1 clear, then a clear coinciding with a set.
        ovf_clr = 1'b1; inp_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; inp_clr = 1'b0;
        check("R6 cleared", {inp_flag, ovf_flag, ovf_irq}, 3'b000);
        hold_bit(1'b0, 1'b0);
        load_and_clear(16'hFFFF);
        open_rise();
        ovf_clr = 1'b1; inp_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; inp_clr = 1'b0;
        check("R6 set wins", {inp_flag, ovf_flag}, 2'b11);

        // R9: clock select applies in the same cycle.
        hold_bit(1'b0, 1'b0);
        load_and_clear(16'h00FF);
        open_rise();
        clk_sel = 2'b01; #0.5;
        check("R9 sel acc", tcnt_tick, 1'b1);
        clk_sel = 2'b11; #0.5;
        check("R9 sel full no carry", tcnt_tick, 1'b0);
        clk_sel = 2'b10; #0.5;
        check("R9 sel low carry", tcnt_tick, 1'b1);
        clk_sel = 2'b00; presc_tick = 1'b1; #0.5;
        check("R9 sel presc", tcnt_tick, 1'b1);
        presc_tick = 1'b0;
        @(negedge clk);
        check("R9 count after carry", cnt_q, 16'h0100);
        hold_bit(1'b0, 1'b0);
        load_and_clear(16'hFFFF);
        open_rise();
        clk_sel = 2'b11; #0.5;
        check("R9 sel full carry", tcnt_tick, 1'b1);
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule